// File: doc/BRIEF.md
# Flash Thermometer-to-Binary Encoder

This block takes the raw comparator word of a flash converter and turns it into a binary sample. The comparator word has 256 bits, and bit i is the comparator with the i-th lowest threshold. When the converter works as intended, the word has ones from bit 0 up to the crossing point and zeros above it. The design splits the word into four columns of 64 comparators. Each column finds its own crossing as a 6-bit index. A column encoder then picks the highest column that holds a crossing, and that column number forms the two top output bits.

A lone comparator that disagrees with its neighbours must not cause a large code error. Before the crossing is located, each bit is replaced by the majority of itself and its two neighbours. This bounds the damage from any single out-of-order bit to one code. When the top two comparators are both set, the input is treated as overrange. In that case a flag is raised and all data bits are forced high.

Two coding controls select the output format. One inverts the top bit, which gives offset two's complement. The other inverts the lower seven bits. Setting both gives fully inverted binary. A data-ready line toggles once for each new output word, and a third control sets its polarity.

Top module: `flash_therm_enc`

## Requirements
- R1: While reset is held, the code output is 0x00, the overrange flag is 0, and the data-ready pin equals the polarity control.
- R2: A word sampled at a rising clock edge appears on the outputs right after the next rising edge. Every new word gives exactly one new result, so the latency is one cycle.
- R3: Take a clean thermometer word with bits 0..c-1 set and bits c..255 clear, for c from 0 to 255, with both coding controls low. The code output is c in straight binary. This holds at every column boundary (63/64, 127/128, 191/192).
- R4: When comparators 254 and 255 are both set, the overrange flag is 1 and the code output is 0xFF, whatever the coding controls are.
- R5: If comparator 255 is set while comparator 254 is clear, the overrange flag stays 0. The code then follows the crossing below.
- R6: A lone set bit two or more places above the crossing has no effect on the code. A lone clear bit three or more places below the top set bit also has no effect.
- R7: A lone set bit at position c+1 above a clean crossing at c gives code c+1. A lone clear bit at position c-2 gives code c-1.
- R8: With the top-bit control high and the low-bit control low, the output is c XOR 0x80 (offset two's complement).
- R9: With the low-bit control high, bits 6..0 are inverted, giving c XOR 0x7F. With both controls high, the output is c XOR 0xFF.
- R10: The coding controls are sampled in the same clock edge as the comparator word. A control change therefore applies only to the words sampled alongside it.
- R11: The data-ready state is 0 after reset. It toggles at every rising edge from the second one after reset. The polarity control XORs onto the pin with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| therm_i | input | 256 | Comparator word, bit 0 = lowest threshold |
| msb_inv_i | input | 1 | Invert the top output bit |
| lsb_inv_i | input | 1 | Invert the lower seven output bits |
| rdy_inv_i | input | 1 | Invert the data-ready pin |
| code_o | output | 8 | Binary sample |
| over_o | output | 1 | Overrange flag |
| rdy_o | output | 1 | Data-ready toggle |

## Verification
The embedded properties check on every cycle that overrange forces the code to all ones. They also check that a clear top comparator never raises the flag, that an all-zero word returns exactly the inversion mask one cycle later, and that the data-ready state flips on every edge once the pipeline is full. Other behaviours can only be shown by the bench's directed words:
- the exact code for crossings at column edges,
- the specific one-code shifts caused by bubbles next to the crossing,
- bubbles far from the crossing being ignored,
- the three inversion modes changing from one cycle to the next.

// File: rtl/flash_therm_enc.sv
module flash_therm_enc #(
  parameter int COLS  = 4,
  parameter int COL_W = 64
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic [COLS*COL_W-1:0]                      therm_i,
  input  logic                                       msb_inv_i,
  input  logic                                       lsb_inv_i,
  input  logic                                       rdy_inv_i,
  output logic [$clog2(COL_W)+$clog2(COLS)-1:0]      code_o,
  output logic                                       over_o,
  output logic                                       rdy_o
);
  localparam int N     = COLS * COL_W;
  localparam int IDX_W = $clog2(COL_W);
  localparam int SEL_W = $clog2(COLS);
  localparam int OUT_W = IDX_W + SEL_W;
  localparam int CQ_W  = IDX_W + 1;

  // capture stage (rising edge)
  logic [N-1:0] t_q;
  logic         minv_a, linv_a, v_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q    <= '0;
      minv_a <= 1'b0;
      linv_a <= 1'b0;
      v_a    <= 1'b0;
    end else begin
      t_q    <= therm_i;
      minv_a <= msb_inv_i;
      linv_a <= lsb_inv_i;
      v_a    <= 1'b1;
    end
  end

  // majority smoothing: below bit 0 reads as one, above the top reads as zero
  logic [N+1:0] ext;
  logic [N-1:0] sm;
  logic [N:0]   sm_ext;
  logic [N-1:0] edge_v;

  assign ext    = {1'b0, t_q, 1'b1};
  assign sm_ext = {sm, 1'b1};

  for (genvar i = 0; i < N; i++) begin : g_smooth
    assign sm[i] = (ext[i] & ext[i+1]) | (ext[i] & ext[i+2]) | (ext[i+1] & ext[i+2]);
    assign edge_v[i] = sm_ext[i] & ~sm_ext[i+1];
  end

  // per-column decode of the highest crossing
  logic [COLS*CQ_W-1:0] col_d;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [COL_W-1:0] seg;
    logic [IDX_W-1:0] idx;
    assign seg = edge_v[c*COL_W +: COL_W];
    always_comb begin
      idx = '0;
      for (int j = 0; j < COL_W; j++)
        if (seg[j]) idx = IDX_W'(j);
    end
    assign col_d[c*CQ_W +: CQ_W] = {|seg, idx};
  end

  // column latches (falling edge)
  logic [COLS*CQ_W-1:0] col_q;
  logic                 ovr_b, minv_b, linv_b, v_b;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      ovr_b  <= 1'b0;
      minv_b <= 1'b0;
      linv_b <= 1'b0;
      v_b    <= 1'b0;
    end else begin
      col_q  <= col_d;
      ovr_b  <= sm[N-1];
      minv_b <= minv_a;
      linv_b <= linv_a;
      v_b    <= v_a;
    end
  end

  // column encoder: highest column holding a crossing wins
  logic [SEL_W-1:0] sel;
  logic [IDX_W-1:0] low;

  always_comb begin
    sel = '0;
    low = '0;
    for (int c = 0; c < COLS; c++)
      if (col_q[c*CQ_W + IDX_W]) begin
        sel = SEL_W'(c);
        low = col_q[c*CQ_W +: IDX_W];
      end
  end

  logic [OUT_W-1:0] mask;
  logic             rdy_q;
  assign mask = {minv_b, {(OUT_W-1){linv_b}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o <= '0;
      over_o <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      code_o <= ovr_b ? '1 : ({sel, low} ^ mask);
      over_o <= ovr_b;
      if (v_b) rdy_q <= ~rdy_q;
    end
  end

  assign rdy_o = rdy_q ^ rdy_inv_i;

  // R4
  ovr_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    over_o |-> code_o == '1);

  // R5
  top_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!t_q[N-1]) |-> !over_o);

  // R2
  zero_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(t_q == '0) |-> code_o == {$past(minv_a), {(OUT_W-1){$past(linv_a)}}});

  // R11
  rdy_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(v_b) |-> rdy_q != $past(rdy_q));
endmodule

// File: tb/flash_therm_enc_tb.sv
module flash_therm_enc_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] therm = '0;
  logic         minv = 1'b0, linv = 1'b0, drinv = 1'b0;
  logic [7:0]   code;
  logic         over, rdy;

  flash_therm_enc u_dut (
    .clk(clk), .rst_n(rst_n), .therm_i(therm),
    .msb_inv_i(minv), .lsb_inv_i(linv), .rdy_inv_i(drinv),
    .code_o(code), .over_o(over), .rdy_o(rdy)
  );

  always #2 clk = ~clk;

  typedef struct {
    int         due;
    logic [7:0] code;
    logic       ovr;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0, rel_cyc = 0;
  int   n_chk = 0, n_bad = 0;
  bit   done = 0;
  bit   running = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [255:0] thermo(int c);
    logic [255:0] w = '0;
    for (int i = 0; i < c; i++) w[i] = 1'b1;
    return w;
  endfunction

  task automatic check1(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [255:0] w, logic m, logic l, logic [7:0] ec, logic eo, string tag);
    exp_t e;
    @(negedge clk);
    therm = w; minv = m; linv = l;
    e.due = cyc + 2; e.code = ec; e.ovr = eo; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic clean(int c, logic m, logic l, string tag);
    apply(thermo(c), m, l, 8'(c) ^ {m, {7{l}}}, 1'b0, tag);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    while (running && q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      int n;
      logic rexp;
      e = q.pop_front();
      check1({e.tag, " code"}, 32'(code), 32'(e.code));
      check1({e.tag, " ovr"}, 32'(over), 32'(e.ovr));
      n = cyc - rel_cyc;
      rexp = (n >= 1) ? logic'((n - 1) & 1) : 1'b0;
      check1("R11 rdy", 32'(rdy), 32'(rexp ^ drinv));
    end
  end

  initial begin
    #150000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check1("R1 code", 32'(code), 0);
    check1("R1 ovr", 32'(over), 0);
    drinv = 1'b1; #0.5;
    check1("R1 rdy inv", 32'(rdy), 1);
    drinv = 1'b0; #0.5;
    check1("R1 rdy", 32'(rdy), 0);
    @(negedge clk); #1;
    rst_n = 1'b1;
    rel_cyc = cyc;
    running = 1;
    // R3 clean words at boundaries
    clean(0, 0, 0, "R3 c0");
    clean(1, 0, 0, "R3 c1");
    clean(63, 0, 0, "R3 c63");
    clean(64, 0, 0, "R3 c64");
    clean(127, 0, 0, "R3 c127");
    clean(128, 0, 0, "R3 c128");
    clean(191, 0, 0, "R3 c191");
    clean(192, 0, 0, "R3 c192");
    clean(254, 0, 0, "R3 c254");
    clean(255, 0, 0, "R3 c255");
    for (int c = 5; c < 256; c += 37) clean(c, 0, 0, "R3 sweep");
    // R4 overrange under every coding
    apply('1, 0, 0, 8'hFF, 1'b1, "R4 ovr");
    apply('1, 1, 0, 8'hFF, 1'b1, "R4 ovr minv");
    apply('1, 1, 1, 8'hFF, 1'b1, "R4 ovr both");
    // R5 lone top comparator
    begin
      logic [255:0] w = thermo(10); w[255] = 1'b1;
      apply(w, 0, 0, 8'd10, 1'b0, "R5 top bubble");
    end
    // R6 far bubbles
    begin
      logic [255:0] w = thermo(100); w[110] = 1'b1;
      apply(w, 0, 0, 8'd100, 1'b0, "R6 far one");
      w = thermo(100); w[50] = 1'b0;
      apply(w, 0, 0, 8'd100, 1'b0, "R6 far zero");
      // R7 near bubbles
      w = thermo(100); w[101] = 1'b1;
      apply(w, 0, 0, 8'd101, 1'b0, "R7 one above");
      w = thermo(100); w[98] = 1'b0;
      apply(w, 0, 0, 8'd99, 1'b0, "R7 zero below");
      w = thermo(64); w[65] = 1'b1;
      apply(w, 0, 0, 8'd65, 1'b0, "R7 column edge");
    end
    // R8 / R9 / R10 coding changing every cycle
    clean(8'h5A, 1, 0, "R8 minv");
    clean(200, 1, 0, "R8 minv hi");
    clean(8'h5A, 0, 1, "R9 linv");
    clean(200, 1, 1, "R9 both");
    clean(0, 1, 1, "R10 both zero");
    clean(37, 0, 0, "R10 back plain");
    clean(255, 1, 0, "R10 minv top");
    drinv = 1'b1;
    clean(90, 0, 0, "R11 drinv high");
    clean(91, 0, 0, "R11 drinv high2");
    repeat (4) @(negedge clk);
    drinv = 1'b0;
    check1("R2 drained", 32'(q.size()), 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule